// File: doc/BRIEF.md
# Initialization Address Register Bank

This block holds the 32-bit start address of a controller's initialization block and supplies the top address byte that turns 24-bit pointers into full 32-bit bus addresses. Software reaches it through a single register port. One write strobe carries an index and 32 data bits. One read index returns the selected register one clock later. The address is split over a low half-word register and a high half-word register. Each of the two also answers at a second alias index. The bank also holds a sticky start bit and a small array of stored descriptor and buffer pointers.

The address registers change only while the controller is stopped or suspended. Neither reset touches them, and neither does entering the stopped state. The start bit has the opposite behaviour: any reset clears it, and so does the entry into the stopped state. A mode input selects the pointer width. In 24-bit mode, every pointer written into the array gets its top byte replaced by the top address byte in that same write. In 32-bit mode, pointers are stored exactly as written, and the top byte is used only for the initialization address.

Top module: `init_addr_bank`

## Requirements
- R1: A write to index 1 or index 16 loads address bits 15:0 from wr_data[15:0], and a read at either index returns {16'h0, address[15:0]}.
- R2: A write to index 2 or index 17 loads address bits 23:16 from wr_data[7:0] and address bits 31:24 from wr_data[15:8], and a read at either index returns {16'h0, address[31:16]}.
- R3: An accepted write to index 1 or 16 always stores 0 in address bits 1:0. When wr_data[1:0] is nonzero, align_err_o is high for exactly the one cycle after that write.
- R4: Writes to indices 1, 2, 16 and 17 take effect only when stop_i or spnd_i is high at the write edge. Any other such write leaves the address unchanged and raises no alignment error.
- R5: The address is unchanged by rst, by soft_rst and by a rising edge of stop_i.
- R6: A write to index 0 with wr_data[0]=1 sets init_o, whatever the state of stop_i and spnd_i. A write with wr_data[0]=0 leaves init_o unchanged. A read at index 0 returns {31'h0, init_o}.
- R7: init_o is cleared in the cycle after rst, after soft_rst, or after a rising edge of stop_i. A clear wins over a set made at the same edge.
- R8: With ssize32_i low, a write to pointer index PTR_BASE+k stores {address[31:24], wr_data[23:0]}, and a read at that index returns it.
- R9: With ssize32_i high, a pointer write stores wr_data unchanged.
- R10: rd_data is registered: it shows the register selected at the previous edge and is 0 while in reset. Reserved bits and unmapped indices read as 0.
- R11: iaddr_o always presents the full 32-bit initialization address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst | input | 1 | Synchronous soft reset, clears only the start bit |
| stop_i | input | 1 | Controller stopped state |
| spnd_i | input | 1 | Controller suspended state |
| ssize32_i | input | 1 | 1 = 32-bit software pointers, 0 = 24-bit pointers |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write index |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW | Register read index |
| rd_data | output | 32 | Registered read data |
| init_o | output | 1 | Sticky start bit |
| align_err_o | output | 1 | One-cycle pulse after a misaligned accepted low write |
| iaddr_o | output | 32 | Full initialization address |

## Verification
The bench builds the block with its defaults: a 6-bit index, four pointer slots starting at index 32. In that space both alias pairs, the start-bit register, every pointer slot and unmapped indices such as 5 and 63 can all be reached. Under these values the bench writes pointers in both width modes. It also covers writes refused while running, a misaligned low write, and a clear and a set of the start bit landing on the same edge.

// File: rtl/iab_pkg.sv
package iab_pkg;
  localparam int unsigned IDX_INIT     = 0;
  localparam int unsigned IDX_LO       = 1;
  localparam int unsigned IDX_HI       = 2;
  localparam int unsigned IDX_LO_ALIAS = 16;
  localparam int unsigned IDX_HI_ALIAS = 17;
  localparam int unsigned DW           = 32;
  localparam int unsigned HW           = DW / 2;
endpackage

// File: rtl/iab_addr_regs.sv
module iab_addr_regs
  import iab_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [HW-1:0] wr_half,
  input  logic          stop_i,
  input  logic          spnd_i,
  output logic [DW-1:0] iadr_o,
  output logic          align_err_o
);
  logic          accept;
  logic [HW-1:0] lo_q;
  logic [HW-1:0] hi_q;
  logic          err_q;

  assign accept = stop_i | spnd_i;

  // Address storage carries no reset: both resets must leave it alone.
  always_ff @(posedge clk) begin
    if (wr_lo && accept) lo_q <= {wr_half[HW-1:2], 2'b00};
    if (wr_hi && accept) hi_q <= wr_half;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= wr_lo && accept && (wr_half[1:0] != 2'b00);
  end

  assign iadr_o      = {hi_q, lo_q};
  assign align_err_o = err_q;

  assert_hold_when_running_R4: assert property (@(posedge clk) disable iff (rst)
    ((wr_lo || wr_hi) && !(stop_i || spnd_i)) |=> $stable(iadr_o));

  assert_err_needs_accept_R3: assert property (@(posedge clk) disable iff (rst)
    align_err_o |-> $past(stop_i || spnd_i));

  assert_err_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    align_err_o |-> (iadr_o[1:0] == 2'b00));
endmodule

// File: rtl/iab_init_ctl.sv
module iab_init_ctl (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic stop_i,
  input  logic set_req,
  output logic init_o
);
  logic stop_q;
  logic init_q;
  logic stop_rise;

  assign stop_rise = stop_i & ~stop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b0;
      init_q <= 1'b0;
    end else begin
      stop_q <= stop_i;
      if (soft_rst || stop_rise) init_q <= 1'b0;
      else if (set_req)          init_q <= 1'b1;
    end
  end

  assign init_o = init_q;

  assert_init_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (soft_rst || $rose(stop_i)) |=> !init_o);

  assert_init_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (init_o && !soft_rst && !$rose(stop_i)) |=> init_o);
endmodule

// File: rtl/iab_ptr_store.sv
module iab_ptr_store
  import iab_pkg::*;
#(
  parameter int unsigned NPTR = 4,
  parameter int unsigned IW   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          ssize32_i,
  input  logic [7:0]    upper_i,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [NPTR];
  logic [DW-1:0] wr_word;

  assign wr_word = ssize32_i ? wr_data : {upper_i, wr_data[DW-9:0]};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_word;
  end

  assign rd_data = mem[rd_idx];

  assert_upper_sub_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ssize32_i) |=> (mem[$past(wr_idx)][DW-1:DW-8] == $past(upper_i)));

  assert_full_ptr_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ssize32_i) |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/init_addr_bank.sv
module init_addr_bank
  import iab_pkg::*;
#(
  parameter int unsigned AW       = 6,
  parameter int unsigned NPTR     = 4,
  parameter int unsigned PTR_BASE = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          stop_i,
  input  logic          spnd_i,
  input  logic          ssize32_i,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          init_o,
  output logic          align_err_o,
  output logic [DW-1:0] iaddr_o
);
  localparam int unsigned IW = (NPTR > 1) ? $clog2(NPTR) : 1;

  logic          wr_lo, wr_hi, wr_init, wr_ptr;
  logic [AW-1:0] wr_off, rd_off;
  logic          rd_is_ptr;
  logic [DW-1:0] iadr;
  logic [DW-1:0] ptr_word;
  logic [DW-1:0] rd_q;

  assign wr_lo   = wr_en && (wr_addr == AW'(IDX_LO) || wr_addr == AW'(IDX_LO_ALIAS));
  assign wr_hi   = wr_en && (wr_addr == AW'(IDX_HI) || wr_addr == AW'(IDX_HI_ALIAS));
  assign wr_init = wr_en && (wr_addr == AW'(IDX_INIT)) && wr_data[0];
  assign wr_off  = wr_addr - AW'(PTR_BASE);
  assign wr_ptr  = wr_en && (wr_addr >= AW'(PTR_BASE)) && (wr_off < AW'(NPTR));
  assign rd_off  = rd_addr - AW'(PTR_BASE);
  assign rd_is_ptr = (rd_addr >= AW'(PTR_BASE)) && (rd_off < AW'(NPTR));

  iab_addr_regs u_addr (
    .clk         (clk),
    .rst         (rst),
    .wr_lo       (wr_lo),
    .wr_hi       (wr_hi),
    .wr_half     (wr_data[HW-1:0]),
    .stop_i      (stop_i),
    .spnd_i      (spnd_i),
    .iadr_o      (iadr),
    .align_err_o (align_err_o)
  );

  iab_init_ctl u_init (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .stop_i   (stop_i),
    .set_req  (wr_init),
    .init_o   (init_o)
  );

  iab_ptr_store #(.NPTR(NPTR), .IW(IW)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_ptr),
    .wr_idx    (wr_off[IW-1:0]),
    .wr_data   (wr_data),
    .ssize32_i (ssize32_i),
    .upper_i   (iadr[DW-1:DW-8]),
    .rd_idx    (rd_off[IW-1:0]),
    .rd_data   (ptr_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_addr == AW'(IDX_INIT)) begin
      rd_q <= {{(DW-1){1'b0}}, init_o};
    end else if (rd_addr == AW'(IDX_LO) || rd_addr == AW'(IDX_LO_ALIAS)) begin
      rd_q <= {{HW{1'b0}}, iadr[HW-1:0]};
    end else if (rd_addr == AW'(IDX_HI) || rd_addr == AW'(IDX_HI_ALIAS)) begin
      rd_q <= {{HW{1'b0}}, iadr[DW-1:HW]};
    end else if (rd_is_ptr) begin
      rd_q <= ptr_word;
    end else begin
      rd_q <= '0;
    end
  end

  assign rd_data = rd_q;
  assign iaddr_o = iadr;

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == AW'(IDX_LO) || rd_addr == AW'(IDX_HI)) |=> (rd_data[DW-1:HW] == '0));

  assert_alias_match_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == AW'(IDX_LO_ALIAS)) |=> (rd_data == {{HW{1'b0}}, iaddr_o[HW-1:0]}) || $past(wr_lo));
endmodule

// File: tb/sim_init_addr_bank.sv
`timescale 1ns/1ps
module sim_init_addr_bank;
  logic        clk = 1'b0;
  logic        rst, soft_rst, stop_i, spnd_i, ssize32_i, wr_en;
  logic [5:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data, iaddr_o;
  logic        init_o, align_err_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  init_addr_bank u0 (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .stop_i(stop_i), .spnd_i(spnd_i),
    .ssize32_i(ssize32_i), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .init_o(init_o),
    .align_err_o(align_err_o), .iaddr_o(iaddr_o)
  );

  typedef struct packed {
    logic        we;
    logic [5:0]  wa;
    logic [31:0] wd;
    logic        st;
    logic        sp;
    logic        sz;
    logic [5:0]  ra;
    logic [31:0] ex;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 6'd1,  32'h0000_1234, 1'b1, 1'b0, 1'b0, 6'd1,  32'h0000_1234, 8'd1},  // R1
    '{1'b0, 6'd0,  32'h0000_0000, 1'b1, 1'b0, 1'b0, 6'd16, 32'h0000_1234, 8'd1},  // R1 alias
    '{1'b1, 6'd17, 32'hDEAD_A5C3, 1'b0, 1'b1, 1'b0, 6'd2,  32'h0000_A5C3, 8'd2},  // R2
    '{1'b1, 6'd1,  32'h0000_5678, 1'b0, 1'b0, 1'b0, 6'd16, 32'h0000_1234, 8'd4},  // R4
    '{1'b1, 6'd2,  32'h0000_1111, 1'b0, 1'b0, 1'b0, 6'd17, 32'h0000_A5C3, 8'd4},  // R4
    '{1'b1, 6'd16, 32'hFFFF_ABCF, 1'b1, 1'b0, 1'b0, 6'd1,  32'h0000_ABCC, 8'd3},  // R3
    '{1'b1, 6'd32, 32'h1122_3344, 1'b0, 1'b0, 1'b0, 6'd32, 32'hA522_3344, 8'd8},  // R8
    '{1'b1, 6'd33, 32'h1122_3344, 1'b0, 1'b0, 1'b1, 6'd33, 32'h1122_3344, 8'd9},  // R9
    '{1'b0, 6'd0,  32'h0000_0000, 1'b0, 1'b0, 1'b1, 6'd5,  32'h0000_0000, 8'd10}, // R10
    '{1'b1, 6'd34, 32'h00FF_FFFF, 1'b0, 1'b0, 1'b0, 6'd34, 32'hA5FF_FFFF, 8'd8},  // R8
    '{1'b0, 6'd0,  32'h0000_0000, 1'b0, 1'b0, 1'b0, 6'd63, 32'h0000_0000, 8'd10}  // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; soft_rst = 1'b0; stop_i = 1'b0; spnd_i = 1'b0; ssize32_i = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = 6'd0;
    repeat (3) @(negedge clk);
    chk("R10 reset rd_data", rd_data, 32'h0);
    chk("R7 reset init", {31'h0, init_o}, 32'h0);
    chk("R3 reset align_err", {31'h0, align_err_o}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      stop_i = VEC[i].st; spnd_i = VEC[i].sp; ssize32_i = VEC[i].sz;
      wr_en = VEC[i].we; wr_addr = VEC[i].wa; wr_data = VEC[i].wd;
      @(negedge clk); wr_en = 1'b0; rd_addr = VEC[i].ra;
      @(negedge clk);
      chk($sformatf("R%0d vector %0d", VEC[i].rq, i), rd_data, VEC[i].ex);
    end

    chk("R11 full address", iaddr_o, 32'hA5C3_ABCC);

    // R5: resets and stop entry keep the address
    stop_i = 1'b0; spnd_i = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); chk("R10 rd_data in reset", rd_data, 32'h0); rst = 1'b0;
    rd(6'd1, v);  chk("R5 low after rst", v, 32'h0000_ABCC);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    rd(6'd17, v); chk("R5 high after soft_rst/stop", v, 32'h0000_A5C3);
    chk("R5 R11 full address kept", iaddr_o, 32'hA5C3_ABCC);

    // R6/R7 start bit
    wr(6'd0, 32'h1); chk("R6 init set", {31'h0, init_o}, 32'h1);
    rd(6'd0, v);     chk("R6 init readback", v, 32'h1);
    wr(6'd0, 32'h0); chk("R6 write 0 no effect", {31'h0, init_o}, 32'h1);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk("R7 soft_rst clears", {31'h0, init_o}, 32'h0);
    wr(6'd0, 32'h1);
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); chk("R7 stop rise clears", {31'h0, init_o}, 32'h0);
    wr(6'd0, 32'h1); chk("R6 set while stopped", {31'h0, init_o}, 32'h1);
    @(negedge clk); stop_i = 1'b0;
    @(negedge clk); stop_i = 1'b1; wr_en = 1'b1; wr_addr = 6'd0; wr_data = 32'h1;
    @(negedge clk); wr_en = 1'b0;
    chk("R7 clear wins over set", {31'h0, init_o}, 32'h0);
    wr(6'd0, 32'h1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R7 rst clears", {31'h0, init_o}, 32'h0);

    // R3 alignment pulse (stop_i still high)
    @(negedge clk); wr_en = 1'b1; wr_addr = 6'd1; wr_data = 32'h0000_0003;
    @(negedge clk); wr_en = 1'b0;
    chk("R3 align_err pulse", {31'h0, align_err_o}, 32'h1);
    @(negedge clk);
    chk("R3 align_err one cycle", {31'h0, align_err_o}, 32'h0);
    rd(6'd1, v); chk("R3 low bits forced", v, 32'h0000_0000);
    stop_i = 1'b0; spnd_i = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_addr = 6'd16; wr_data = 32'h0000_0007;
    @(negedge clk); wr_en = 1'b0;
    chk("R4 no error when refused", {31'h0, align_err_o}, 32'h0);
    rd(6'd16, v); chk("R4 refused write", v, 32'h0000_0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule